// File: doc/BRIEF.md
# Bounded Table Branch Unit

This unit carries out a multiway branch whose case table lives in the instruction stream, directly after the branch instruction. It takes an index register value, a 16-bit upper bound, a 2-bit element size code, the address of the branch instruction and a fall-back target. It checks the index as a signed number against zero and the bound. For an index inside the range, it reads one table element through an instruction-side read port, sign-extends the element and scales it by four, and adds the result to a table-relative base. An index outside the range selects the fall-back target without touching memory.

The table stores displacements, not absolute addresses, so it is position independent and elements can be as narrow as one byte. A fault reported with the read response ends the branch with an exception strobe instead of a redirect. The index is taken as already normalised so that the first case is zero.

Top module: `jtt_branch_unit`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_req_valid`, `redir_valid` and `exc_valid` are 0.
- R2: An index that is negative as a signed 64-bit value, or greater than `req_max`, issues no memory request. `redir_valid` is high in the cycle after the request is accepted, and `redir_target` then equals `req_default`.
- R3: For an index in 0..`req_max`, `mem_req_valid` rises in the cycle after acceptance with `mem_req_addr` = `req_pc` + 4 + (index << `req_size`). The request and its address stay unchanged until a cycle in which `mem_req_ready` is high.
- R4: The size code selects the element width: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits. `mem_rsp_data` holds the addressed byte in bits [7:0], little-endian. Bits above the element width are ignored, and the element is sign-extended.
- R5: On the table path, the target is B + (element << 2) modulo 2^64. B is `req_pc` + ((`req_max`+1) << `req_size`), rounded up to the next multiple of 4. The target is therefore always 4-byte aligned.
- R6: A response with `mem_rsp_fault` high raises `exc_valid` instead of `redir_valid`. The two are never high together.
- R7: `redir_valid` and `exc_valid` are single-cycle pulses in the cycle after the accepted response. `req_ready` returns in the cycle after the pulse.
- R8: `req_ready` is high only when the unit is idle. A request held while the unit is busy has no effect on the branch in progress.
- R9: The bound covers the full 16-bit range, so an index of 65535 with `req_max` = 65535 is in range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Branch request |
| req_ready | output | 1 | Unit idle, request accepted when both are high |
| req_index | input | 64 | Zero-based case index, signed |
| req_max | input | 16 | Largest valid index |
| req_size | input | 2 | Element size code |
| req_pc | input | 64 | Address of the branch instruction |
| req_default | input | 64 | Fall-back target |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Read request taken |
| mem_req_addr | output | 64 | Byte address of the element |
| mem_rsp_valid | input | 1 | Read response |
| mem_rsp_data | input | 64 | Read data, addressed byte in [7:0] |
| mem_rsp_fault | input | 1 | Execute permission fault on the read |
| redir_valid | output | 1 | Redirect strobe |
| redir_target | output | 64 | Branch target |
| exc_valid | output | 1 | Exception strobe |

## Verification
If the state register is wrong, it shows at the ports within one cycle. `req_ready` or `mem_req_valid` would be high in the wrong phase, or a strobe would fail to drop after one cycle. A stale base or size register gives a wrong target on the very next strobe. A wrong bound decision shows up as a memory request where none is allowed, or as a missing one. The bench predicts every output in every cycle of each branch, so the first deviating cycle is reported.

// File: rtl/jtt_branch_unit.sv
module jtt_branch_unit #(
  parameter int AW   = 64,
  parameter int MW   = 16,
  parameter int ILEN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_index,
  input  logic [MW-1:0] req_max,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_pc,
  input  logic [AW-1:0] req_default,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [AW-1:0] mem_rsp_data,
  input  logic          mem_rsp_fault,
  output logic          redir_valid,
  output logic [AW-1:0] redir_target,
  output logic          exc_valid
);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WAIT, S_REDIR} st_t;

  st_t           st;
  logic [AW-1:0] addr_q, base_q, tgt_q, elem;
  logic [1:0]    size_q;
  logic          fault_q, use_def;

  wire           accept   = req_valid && (st == S_IDLE);
  wire           in_range = !req_index[AW-1] &&
                            (req_index <= {{(AW-MW){1'b0}}, req_max});
  wire [AW-1:0]  span     = AW'({1'b0, req_max} + (MW+1)'(1)) << req_size;
  wire [AW-1:0]  base_raw = req_pc + span + AW'(3);
  wire [AW-1:0]  idx_off  = AW'(req_index[MW-1:0]) << req_size;

  always_comb begin
    case (size_q)
      2'd0:    elem = {{(AW-8){mem_rsp_data[7]}},   mem_rsp_data[7:0]};
      2'd1:    elem = {{(AW-16){mem_rsp_data[15]}}, mem_rsp_data[15:0]};
      2'd2:    elem = {{(AW-32){mem_rsp_data[31]}}, mem_rsp_data[31:0]};
      default: elem = mem_rsp_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      base_q  <= '0;
      tgt_q   <= '0;
      size_q  <= '0;
      fault_q <= 1'b0;
      use_def <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          size_q  <= req_size;
          fault_q <= 1'b0;
          if (in_range) begin
            st      <= S_FETCH;
            use_def <= 1'b0;
            addr_q  <= req_pc + AW'(ILEN) + idx_off;
            base_q  <= {base_raw[AW-1:2], 2'b00};
          end else begin
            st      <= S_REDIR;
            use_def <= 1'b1;
            tgt_q   <= req_default;
          end
        end
        S_FETCH: if (mem_req_ready) st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          st      <= S_REDIR;
          fault_q <= mem_rsp_fault;
          tgt_q   <= base_q + {elem[AW-3:0], 2'b00};
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_FETCH);
  assign mem_req_addr  = addr_q;
  assign redir_valid   = (st == S_REDIR) && !fault_q;
  assign exc_valid     = (st == S_REDIR) && fault_q;
  assign redir_target  = tgt_q;

  AST_OOR_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !in_range |=> redir_valid && !mem_req_valid && redir_target == $past(req_default)); // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R3
  AST_TGT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid && !use_def |-> redir_target[1:0] == 2'b00); // R5
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(redir_valid && exc_valid)); // R6
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid || exc_valid) |=> !redir_valid && !exc_valid && req_ready); // R7
  AST_NO_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready); // R8

endmodule

// File: tb/jtt_branch_unit_tb_top.sv
module jtt_branch_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_index = '0;
  logic [15:0] req_max = '0;
  logic [1:0]  req_size = '0;
  logic [63:0] req_pc = '0;
  logic [63:0] req_default = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        mem_rsp_fault = 1'b0;
  logic        redir_valid;
  logic [63:0] redir_target;
  logic        exc_valid;

  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;

  jtt_branch_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_index(req_index), .req_max(req_max), .req_size(req_size),
    .req_pc(req_pc), .req_default(req_default),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_fault(mem_rsp_fault),
    .redir_valid(redir_valid), .redir_target(redir_target), .exc_valid(exc_valid)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle_outputs(input string req);
    chk(req, "req_ready", 64'(req_ready), 64'd1);
    chk(req, "mem_req_valid", 64'(mem_req_valid), 64'd0);
    chk(req, "redir_valid", 64'(redir_valid), 64'd0);
    chk(req, "exc_valid", 64'(exc_valid), 64'd0);
  endtask

  function automatic logic [63:0] widen(input logic [63:0] raw, input int sz);
    longint v;
    int bits;
    bits = 8 << sz;
    v = longint'(raw);
    if (bits < 64) begin
      v = v << (64 - bits);
      v = v >>> (64 - bits);
    end
    return 64'(v);
  endfunction

  function automatic logic [63:0] model_target(input logic [63:0] pc, input int mx,
                                               input int sz, input logic [63:0] raw);
    logic [63:0] b;
    b = pc + (64'(mx + 1) << sz);
    b = (b + 64'd3) & ~64'd3;
    return b + (widen(raw, sz) << 2);
  endfunction

  task automatic branch(input string tag, input logic [63:0] idx, input int mx, input int sz,
                        input logic [63:0] pc, input logic [63:0] dflt,
                        input logic [63:0] raw, input bit fault,
                        input int rdy_wait, input int rsp_wait, input bit noisy);
    longint sidx;
    bit inr;
    logic [63:0] exp_tgt;
    sidx = longint'(idx);
    inr = (sidx >= 0) && (sidx <= longint'(mx));
    exp_tgt = model_target(pc, mx, sz, raw);
    @(negedge clk);
    chk("R8", {tag, " ready before request"}, 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_index = idx; req_max = 16'(mx); req_size = 2'(sz);
    req_pc = pc; req_default = dflt;
    @(negedge clk);
    if (noisy) begin
      req_index = 64'hFFFF_FFFF_FFFF_FFFF; req_default = 64'hDEAD_0000_0000_BEE0;
      req_size = 2'(sz + 1); req_pc = 64'h1234;
    end else req_valid = 1'b0;
    if (!inr) begin
      chk("R2", {tag, " mem_req_valid"}, 64'(mem_req_valid), 64'd0);
      chk("R2", {tag, " redir_valid"}, 64'(redir_valid), 64'd1);
      chk("R2", {tag, " default target"}, redir_target, dflt);
      req_valid = 1'b0;
    end else begin
      for (int k = 0; k <= rdy_wait; k++) begin
        mem_req_ready = (k == rdy_wait);
        chk("R3", {tag, " mem_req_valid"}, 64'(mem_req_valid), 64'd1);
        chk("R3", {tag, " mem_req_addr"}, mem_req_addr, pc + 64'd4 + (64'(idx[15:0]) << sz));
        chk("R8", {tag, " busy ready"}, 64'(req_ready), 64'd0);
        @(negedge clk);
      end
      mem_req_ready = 1'b0;
      for (int k = 0; k < rsp_wait; k++) begin
        chk("R3", {tag, " request dropped"}, 64'(mem_req_valid), 64'd0);
        chk("R7", {tag, " no early strobe"}, 64'(redir_valid | exc_valid), 64'd0);
        @(negedge clk);
      end
      req_valid = 1'b0;
      mem_rsp_valid = 1'b1; mem_rsp_data = raw; mem_rsp_fault = fault;
      @(negedge clk);
      mem_rsp_valid = 1'b0; mem_rsp_data = 64'hA5A5_A5A5_A5A5_A5A5; mem_rsp_fault = 1'b0;
      if (fault) begin
        chk("R6", {tag, " exc_valid"}, 64'(exc_valid), 64'd1);
        chk("R6", {tag, " redir_valid"}, 64'(redir_valid), 64'd0);
      end else begin
        chk("R7", {tag, " redir_valid"}, 64'(redir_valid), 64'd1);
        chk("R5", {tag, " target"}, redir_target, exp_tgt);
        chk("R5", {tag, " aligned"}, 64'(redir_target[1:0]), 64'd0);
      end
    end
    @(negedge clk);
    idle_outputs({"R7 ", tag});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    idle_outputs("R1");
    // R2 bound cases
    branch("R2 above", 64'd11, 10, 2, 64'h1000, 64'h4440, 64'd0, 0, 0, 0, 0);
    branch("R2 negative", 64'hFFFF_FFFF_FFFF_FFFF, 10, 1, 64'h1000, 64'h8888, 64'd0, 0, 0, 0, 0);
    branch("R2 huge", 64'h0000_0001_0000_0000, 65535, 0, 64'h20, 64'h77C, 64'd0, 0, 0, 0, 0);
    // R4 sizes with upper junk, R3 address, R5 target
    branch("R4 byte neg", 64'd3, 9, 0, 64'h2000, 64'h0, 64'hFFFF_FFFF_FFFF_FF80, 0, 0, 1, 0);
    branch("R4 byte pos", 64'd0, 0, 0, 64'h2004, 64'h0, 64'h1234_5678_9ABC_DE7F, 0, 2, 0, 0);
    branch("R4 half", 64'd10, 10, 1, 64'h3000, 64'h0, 64'hFFFF_FFFF_0000_8001, 0, 1, 3, 0);
    branch("R4 word", 64'd5, 7, 2, 64'h4008, 64'h0, 64'h0000_0000_8000_0000, 0, 0, 0, 0);
    branch("R4 dword", 64'd2, 3, 3, 64'h500C, 64'h0, 64'hFFFF_FFFF_FFFF_FFF0, 0, 3, 2, 0);
    // R9 full bound
    branch("R9 max", 64'd65535, 65535, 3, 64'h1_0000, 64'h0, 64'h0000_0000_0001_0000, 0, 0, 0, 0);
    // R5 wrap modulo 2^64
    branch("R5 wrap", 64'd1, 1, 2, 64'hFFFF_FFFF_FFFF_FFF8, 64'h0, 64'h0000_0000_0000_0010, 0, 0, 0, 0);
    // R6 fault
    branch("R6 fault", 64'd4, 8, 1, 64'h6000, 64'h0, 64'h0000_0000_0000_0042, 1, 1, 1, 0);
    // R8 request held while busy
    branch("R8 noisy", 64'd6, 12, 0, 64'h7000, 64'h9990, 64'h0000_0000_0000_0005, 0, 2, 2, 1);
    branch("R1 after", 64'd1, 2, 1, 64'h8000, 64'h0, 64'h0000_0000_0000_7FFF, 0, 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule